// File: doc/BRIEF.md
# Multiply, Divide and Accumulate Coprocessor

This block is an arithmetic helper that a processor drives through a small 16-bit register port. Software loads two operand registers, then writes a control byte that picks the operation (multiply, multiply-accumulate or unsigned division) and sets a start flag. The block does the work, puts the main result in a 32-bit result register and clears the start flag. A `busy` pin mirrors that flag, and a `done` pin pulses once at the end.

A single 32-bit auxiliary register, reached as two 16-bit halves, has a different job in each mode. A multiply never touches it. A multiply-accumulate takes it as the running sum and writes the new sum back into it. A division leaves the remainder in it. The divider is a restoring radix-2 unit that takes one quotient bit per cycle. Multiply and multiply-accumulate finish one cycle after start.

The register port is a plain control interface: one write strobe, an address and data, with read data decoded combinationally from the address. It has no handshake and no back-pressure, and every access completes in the cycle it is presented.

Top module: `mdac_unit`

## Requirements
- R1: After reset every register reads 0000h, and `busy` and `done` are low.
- R2: The register addresses are: 0 and 1 for operand A low and high, 2 and 3 for operand B low and high, 4 and 5 for auxiliary low and high, 6 for control, 7 for status and 8 and 9 for result low and high (result and status are read-only). The control byte sits in bits 7:0 and is read back with bit 0 cleared once the operation ends.
- R3: The control encoding is: bit 7 set selects division; bit 7 clear with bit 6 set selects multiply-accumulate; both clear selects multiply; bit 3 selects signed (two's complement) operation for multiply and multiply-accumulate; bit 0 is start and busy. A multiply writes the 32-bit product of the low operand halves to the result register and leaves the auxiliary register unchanged.
- R4: A multiply-accumulate replaces the auxiliary register with the auxiliary value plus the product, writes the product to the result register, and keeps `busy` high for exactly one cycle.
- R5: The accumulated sum wraps modulo 2^32. Status bit 0 is set by a multiply-accumulate whose sum overflows (carry out when unsigned, signed overflow when signed) and stays set until status is written.
- R6: A division of {A high, A low} by {B high, B low} puts the unsigned quotient in the result register and the remainder in the auxiliary register. `busy` is high for 34 cycles: 32 quotient steps, then the high remainder half, then the low half.
- R7: A zero divisor gives a quotient of FFFFFFFFh and a remainder equal to the dividend.
- R8: While `busy` is high, writes to the operand, auxiliary and control registers are ignored.
- R9: `done` is high for exactly one cycle, the first cycle in which `busy` is low after an operation.
- R10: A division started after an earlier one has finished gives results that depend only on its own operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| busy | output | 1 | Operation in progress (control bit 0) |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default half width of 16, which makes the operands 16 bits, the accumulator and the dividend 32 bits, and the divider 32 steps long. At that width the random operands reach both carry and signed overflow of the accumulator and divisors from zero up to full 32-bit values. The directed cases add an accumulator preload near the overflow limit, a zero divisor, writes made while busy, and two divisions run back to back.

// File: rtl/mdac_pkg.sv
package mdac_pkg;

  // register addresses
  localparam logic [3:0] A_OPA_LO = 4'd0;
  localparam logic [3:0] A_OPA_HI = 4'd1;
  localparam logic [3:0] A_OPB_LO = 4'd2;
  localparam logic [3:0] A_OPB_HI = 4'd3;
  localparam logic [3:0] A_AUX_LO = 4'd4;
  localparam logic [3:0] A_AUX_HI = 4'd5;
  localparam logic [3:0] A_CTRL   = 4'd6;
  localparam logic [3:0] A_STAT   = 4'd7;
  localparam logic [3:0] A_RES_LO = 4'd8;
  localparam logic [3:0] A_RES_HI = 4'd9;

  // control byte bit positions
  localparam int CTL_START  = 0;
  localparam int CTL_SIGNED = 3;
  localparam int CTL_MAC    = 6;
  localparam int CTL_DIV    = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_DIV,
    ST_WLO
  } mdac_state_e;

endpackage

// File: rtl/mdac_muladd.sv
module mdac_muladd #(
  parameter int HW = 16,
  localparam int DW = 2 * HW
) (
  input  logic [HW-1:0] a,
  input  logic [HW-1:0] b,
  input  logic [DW-1:0] acc,
  input  logic          sgn,
  output logic [DW-1:0] prod,
  output logic [DW-1:0] sum,
  output logic          ovf
);

  logic [DW-1:0] a_ext, b_ext;
  logic [DW:0]   wide_sum;

  // operand extension picks the signed or unsigned product
  always_comb begin
    a_ext = sgn ? {{HW{a[HW-1]}}, a} : {{HW{1'b0}}, a};
    b_ext = sgn ? {{HW{b[HW-1]}}, b} : {{HW{1'b0}}, b};
    prod  = a_ext * b_ext;
  end

  always_comb begin
    wide_sum = {1'b0, acc} + {1'b0, prod};
    sum      = wide_sum[DW-1:0];
    if (sgn)
      ovf = (acc[DW-1] == prod[DW-1]) && (sum[DW-1] != acc[DW-1]);
    else
      ovf = wide_sum[DW];
  end

endmodule

// File: rtl/mdac_divider.sv
module mdac_divider #(
  parameter int DW = 32,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          fin,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder
);

  localparam logic [CW-1:0] LAST = CW'(DW);

  logic          active;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rem_q, quo_q, dvs_q;
  logic [DW:0]   shifted, diff;

  always_comb begin
    shifted = {rem_q, quo_q[DW-1]};
    diff    = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      rem_q  <= '0;
      quo_q  <= dividend;
      dvs_q  <= divisor;
    end else if (active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (!diff[DW]) begin
          rem_q <= diff[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= shifted[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign fin       = active && (cnt == LAST);
  assign quotient  = quo_q;
  assign remainder = rem_q;

  // R6: restoring step keeps the partial remainder below the divisor
  a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dvs_q != '0) |-> (rem_q < dvs_q));

  // R7: a zero divisor ends with an all-ones quotient
  a_r7_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && dvs_q == '0) |-> (&quo_q));

endmodule

// File: rtl/mdac_unit.sv
module mdac_unit
  import mdac_pkg::*;
#(
  parameter int HW = 16,
  localparam int DW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [HW-1:0] reg_wdata,
  output logic [HW-1:0] reg_rdata,
  output logic          busy,
  output logic          done
);

  mdac_state_e   state;
  logic [DW-1:0] opa_q, opb_q, aux_q, res_q;
  logic [7:0]    ctrl_q;
  logic          ovf_q, done_q;

  logic [DW-1:0] m_prod, m_sum, dv_quo, dv_rem;
  logic          m_ovf, dv_fin, dv_start, ctl_launch;

  assign ctl_launch = (state == ST_IDLE) && reg_wr && (reg_addr == A_CTRL)
                      && reg_wdata[CTL_START];
  assign dv_start   = ctl_launch && reg_wdata[CTL_DIV];

  mdac_muladd #(.HW(HW)) i_muladd (
    .a    (opa_q[HW-1:0]),
    .b    (opb_q[HW-1:0]),
    .acc  (aux_q),
    .sgn  (ctrl_q[CTL_SIGNED]),
    .prod (m_prod),
    .sum  (m_sum),
    .ovf  (m_ovf)
  );

  mdac_divider #(.DW(DW)) i_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (dv_start),
    .dividend  (opa_q),
    .divisor   (opb_q),
    .fin       (dv_fin),
    .quotient  (dv_quo),
    .remainder (dv_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      opa_q  <= '0;
      opb_q  <= '0;
      aux_q  <= '0;
      res_q  <= '0;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (reg_wr && reg_addr == A_STAT) ovf_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reg_wr) begin
            case (reg_addr)
              A_OPA_LO: opa_q[HW-1:0]  <= reg_wdata;
              A_OPA_HI: opa_q[DW-1:HW] <= reg_wdata;
              A_OPB_LO: opb_q[HW-1:0]  <= reg_wdata;
              A_OPB_HI: opb_q[DW-1:HW] <= reg_wdata;
              A_AUX_LO: aux_q[HW-1:0]  <= reg_wdata;
              A_AUX_HI: aux_q[DW-1:HW] <= reg_wdata;
              A_CTRL: begin
                ctrl_q <= reg_wdata[7:0];
                if (reg_wdata[CTL_START])
                  state <= reg_wdata[CTL_DIV] ? ST_DIV : ST_EXEC;
              end
              default: ;
            endcase
          end
        end
        ST_EXEC: begin
          res_q <= m_prod;
          if (ctrl_q[CTL_MAC]) begin
            aux_q <= m_sum;
            if (m_ovf) ovf_q <= 1'b1;
          end
          ctrl_q[CTL_START] <= 1'b0;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_DIV: begin
          if (dv_fin) begin
            aux_q[DW-1:HW] <= dv_rem[DW-1:HW];
            state <= ST_WLO;
          end
        end
        ST_WLO: begin
          aux_q[HW-1:0] <= dv_rem[HW-1:0];
          res_q <= dv_quo;
          ctrl_q[CTL_START] <= 1'b0;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_OPA_LO: reg_rdata = opa_q[HW-1:0];
      A_OPA_HI: reg_rdata = opa_q[DW-1:HW];
      A_OPB_LO: reg_rdata = opb_q[HW-1:0];
      A_OPB_HI: reg_rdata = opb_q[DW-1:HW];
      A_AUX_LO: reg_rdata = aux_q[HW-1:0];
      A_AUX_HI: reg_rdata = aux_q[DW-1:HW];
      A_CTRL:   reg_rdata = HW'(ctrl_q);
      A_STAT:   reg_rdata = HW'(ovf_q);
      A_RES_LO: reg_rdata = res_q[HW-1:0];
      A_RES_HI: reg_rdata = res_q[DW-1:HW];
      default:  reg_rdata = '0;
    endcase
  end

  assign busy = ctrl_q[CTL_START];
  assign done = done_q;

  // R3: a plain multiply leaves the auxiliary register alone
  a_r3_mul_aux_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && !ctrl_q[CTL_MAC]) |=> $stable(aux_q));

  // R4: single-cycle execute for multiply and multiply-accumulate
  a_r4_exec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC) |=> (state == ST_IDLE && !busy));

  // R5: the sticky flag is only raised by a multiply-accumulate
  a_r5_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ($past(state) == ST_EXEC && $past(ctrl_q[CTL_MAC])));

  // R6: the low remainder half follows the high half
  a_r6_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WLO) |-> $past(dv_fin));

  // R8: bus writes to the auxiliary register are dropped while dividing
  a_r8_aux_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DIV && !dv_fin && reg_wr && reg_addr == A_AUX_LO)
    |=> $stable(aux_q));

  // R9: completion pulse follows the fall of busy
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

// File: tb/test_mdac_unit.sv
module test_mdac_unit;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] OPA_LO = 4'd0, OPA_HI = 4'd1, OPB_LO = 4'd2,
                         OPB_HI = 4'd3, AUX_LO = 4'd4, AUX_HI = 4'd5,
                         CTRL = 4'd6, STAT = 4'd7, RES_LO = 4'd8,
                         RES_HI = 4'd9;

  localparam logic [7:0] C_MULU = 8'h01, C_MULS = 8'h09, C_MACU = 8'h41,
                         C_MACS = 8'h49, C_DIV = 8'h81, C_DIV2 = 8'hC1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        busy, done;

  int checks = 0;
  int errors = 0;

  mdac_unit i_mdac_unit (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .busy (busy), .done (done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R6): actual no finish, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic rd32(input logic [3:0] lo, output logic [31:0] v);
    logic [15:0] l, h;
    rd(lo, l);
    rd(lo + 4'd1, h);
    v = {h, l};
  endtask

  task automatic set_ops(input logic [31:0] a, input logic [31:0] b);
    wr(OPA_LO, a[15:0]); wr(OPA_HI, a[31:16]);
    wr(OPB_LO, b[15:0]); wr(OPB_HI, b[31:16]);
  endtask

  task automatic set_aux(input logic [31:0] v);
    wr(AUX_LO, v[15:0]); wr(AUX_HI, v[31:16]);
  endtask

  // start an operation, count busy cycles, check the done pulse
  task automatic run(input logic [7:0] code, input int exp_cyc, input string req);
    int n = 0;
    wr(CTRL, {8'h00, code});
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
    check({req, " busy cycles"}, n, exp_cyc);
    check("R9 done high", {31'd0, done}, 1);
    @(negedge clk);
    check("R9 done single", {31'd0, done}, 0);
  endtask

  function automatic logic [31:0] mul_ref(input logic [15:0] a, input logic [15:0] b, input bit s);
    longint p;
    if (s) p = longint'($signed(a)) * longint'($signed(b));
    else   p = longint'(a) * longint'(b);
    return p[31:0];
  endfunction

  function automatic bit ovf_ref(input logic [31:0] acc, input logic [31:0] p, input bit s);
    longint t;
    if (s) begin
      t = longint'($signed(acc)) + longint'($signed(p));
      return (t > 64'sd2147483647) || (t < -64'sd2147483648);
    end
    t = longint'(acc) + longint'(p);
    return t > 64'sd4294967295;
  endfunction

  task automatic do_mac(input logic [15:0] a, input logic [15:0] b, input logic [31:0] acc, input bit s);
    logic [31:0] v, p;
    logic [15:0] st;
    p = mul_ref(a, b, s);
    set_ops({16'h0, a}, {16'h0, b});
    set_aux(acc);
    wr(STAT, 16'h0);
    run(s ? C_MACS : C_MACU, 1, "R4 mac");
    rd32(AUX_LO, v);  check("R4 mac sum", v, acc + p);
    rd32(RES_LO, v);  check("R4 mac product", v, p);
    rd(STAT, st);     check("R5 overflow flag", {16'h0, st}, {31'd0, ovf_ref(acc, p, s)});
  endtask

  task automatic do_div(input logic [31:0] n, input logic [31:0] d, input logic [7:0] code, input string req);
    logic [31:0] v, q, r;
    q = (d == 0) ? 32'hFFFF_FFFF : n / d;
    r = (d == 0) ? n : n % d;
    set_ops(n, d);
    run(code, 34, "R6 divide");
    rd32(RES_LO, v); check({req, " quotient"}, v, q);
    rd32(AUX_LO, v); check({req, " remainder"}, v, r);
  endtask

  initial begin
    logic [31:0] v;
    logic [15:0] h;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), h);
      check("R1 reset register", {16'h0, h}, 0);
    end
    check("R1 busy after reset", {31'd0, busy}, 0);
    check("R1 done after reset", {31'd0, done}, 0);

    // R2 readback of written registers
    set_ops(32'h1234_5678, 32'h9ABC_DEF0);
    rd32(OPA_LO, v); check("R2 operand A readback", v, 32'h1234_5678);
    rd32(OPB_LO, v); check("R2 operand B readback", v, 32'h9ABC_DEF0);
    wr(CTRL, 16'h0048);
    rd(CTRL, h);     check("R2 control readback", {16'h0, h}, 32'h48);

    // R3 multiply: product in result, auxiliary untouched
    set_ops(32'h0000_FFFF, 32'h0000_FFFF);
    set_aux(32'hDEAD_BEEF);
    run(C_MULU, 1, "R3 multiply");
    rd32(RES_LO, v); check("R3 unsigned product", v, 32'hFFFE_0001);
    rd32(AUX_LO, v); check("R3 aux kept", v, 32'hDEAD_BEEF);
    rd(CTRL, h);     check("R2 control after op", {16'h0, h}, 32'h00);
    run(C_MULS, 1, "R3 multiply");
    rd32(RES_LO, v); check("R3 signed product", v, 32'h0000_0001);
    for (int i = 0; i < 10; i++) begin
      logic [15:0] a, b;
      bit s;
      a = 16'($urandom); b = 16'($urandom); s = 1'($urandom);
      set_ops({16'h0, a}, {16'h0, b});
      run(s ? C_MULS : C_MULU, 1, "R3 multiply");
      rd32(RES_LO, v); check("R3 random product", v, mul_ref(a, b, s));
      rd32(AUX_LO, v); check("R3 random aux kept", v, 32'hDEAD_BEEF);
    end

    // R4/R5 multiply-accumulate, directed and random
    do_mac(16'h0002, 16'h0001, 32'hFFFF_FFFF, 1'b0);
    do_mac(16'h0001, 16'h0001, 32'h7FFF_FFFF, 1'b1);
    do_mac(16'hFFFD, 16'h0004, 32'h0000_0005, 1'b1);
    do_mac(16'h8000, 16'h8000, 32'h8000_0000, 1'b1);
    for (int i = 0; i < 12; i++)
      do_mac(16'($urandom), 16'($urandom), $urandom, 1'($urandom));

    // R5 sticky flag survives a later clean accumulate, cleared by write
    do_mac(16'h0002, 16'h0001, 32'hFFFF_FFFF, 1'b0);
    set_ops(32'h1, 32'h1);
    set_aux(32'h0);
    run(C_MACU, 1, "R4 mac");
    rd(STAT, h);  check("R5 sticky kept", {16'h0, h}, 1);
    wr(STAT, 16'h0);
    rd(STAT, h);  check("R5 cleared by write", {16'h0, h}, 0);

    // R6/R7/R10 division
    do_div(32'd100, 32'd7, C_DIV, "R6");
    do_div(32'hFFFF_FFFF, 32'h0001_0000, C_DIV2, "R6");
    do_div(32'h89AB_CDEF, 32'h0, C_DIV, "R7");
    do_div(32'd5, 32'd9, C_DIV, "R6");
    do_div(32'hF000_0000, 32'hF000_0001, C_DIV, "R10");
    do_div(32'h0000_0400, 32'h0000_0020, C_DIV, "R10");
    for (int i = 0; i < 10; i++) begin
      logic [31:0] n, d;
      n = $urandom;
      d = (i % 3 == 0) ? ($urandom & 32'h0000_00FF) : $urandom >> ($urandom % 32);
      do_div(n, d, C_DIV, "R6");
    end

    // R8 writes while dividing are dropped
    set_ops(32'd1000, 32'd3);
    set_aux(32'h1111_2222);
    wr(CTRL, {8'h00, C_DIV});
    wr(AUX_LO, 16'hABCD);
    wr(OPA_LO, 16'h0005);
    wr(CTRL, 16'h0001);
    while (busy) @(negedge clk);
    rd32(AUX_LO, v); check("R8 aux write ignored", v, 32'd1);
    rd32(RES_LO, v); check("R8 quotient intact", v, 32'd333);
    rd32(OPA_LO, v); check("R8 operand write ignored", v, 32'd1000);
    rd(CTRL, h);     check("R8 control write ignored", {16'h0, h}, 32'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule